// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block sits next to an 8/16-bit arithmetic unit and turns each operation's operands, result and carry/borrow into a set of condition bits. It holds those bits in a 16-bit flag word together with three mode bits that software sets directly. The six condition bits are carry, even parity, nibble carry, zero, negative and signed overflow. The three mode bits are single-step, interrupt enable and string-direction.

Each clock, the caller gives the operation class, either add, subtract, logic or hold, and a byte/word select. When the status enable is high, the condition bits are recomputed from these inputs and loaded at the next rising edge. The mode bits have their own per-bit write enables and do not depend on the status path. Only nine positions of the word are live. All other positions always read as zero.

Top module: `alu_flag_unit`

## Requirements
- R1: After synchronous reset every bit of `flags_q` is 0. Bits 1, 3, 5, 12, 13, 14 and 15 are always 0.
- R2: On add (`op_class`=0) or subtract (`op_class`=1) with `stat_we`=1, bit 0 (carry) takes the value of `alu_carry` at the next edge. `alu_carry` carries the carry out of, or the borrow into, the most significant bit of the active width.
- R3: Bit 2 (parity) is set when the low 8 bits of the result hold an even number of ones. This rule applies in both byte and word mode.
- R4: On add, bit 4 (nibble carry) is set on a carry from bit 3 into bit 4. On subtract, it is set on a borrow from bit 4 into bit 3.
- R5: Bit 6 (zero) is set when the result is zero over the active width: 8 bits when `word_mode`=0 and 16 bits when `word_mode`=1. Upper result bits are ignored in byte mode.
- R6: Bit 7 (negative) copies the most significant bit of the active width: bit 7 in byte mode, bit 15 in word mode.
- R7: Bit 11 (overflow) is set when the two's-complement result of an add or subtract does not fit in the active width.
- R8: Bits 8 (single-step), 9 (interrupt enable) and 10 (direction, 1 = decrementing string addresses) are loaded from `ctl_wdata[0]`, `[1]` and `[2]` when the matching `ctl_we` bit is 1. Otherwise they keep their value, whatever the status inputs do.
- R9: A logic operation (`op_class`=2) with `stat_we`=1 clears carry, nibble carry and overflow regardless of `alu_carry`, and updates parity, zero and negative.
- R10: When `stat_we`=0, or when `op_class`=3 (hold), the six condition bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 hold |
| word_mode | input | 1 | 1 = 16-bit width, 0 = low 8 bits |
| opnd_a | input | DATA_W | First operand of the ALU operation |
| opnd_b | input | DATA_W | Second operand (subtrahend on subtract) |
| alu_result | input | DATA_W | Result produced by the ALU |
| alu_carry | input | 1 | Carry/borrow at the MSB of the active width |
| stat_we | input | 1 | Load enable for the condition bits |
| ctl_we | input | 3 | Per-bit write enable for the mode bits |
| ctl_wdata | input | 3 | Values for the mode bits |
| flags_q | output | 16 | Registered flag word |

## Verification
The bench builds the block with the default `DATA_W` of 16, which gives it both the full word width and the 8-bit byte half. With that setting it can drive the word-mode corner results 0x8000 and 0x0000 and their byte equivalents 0x80 and 0x00. Byte-mode vectors put non-zero bits in the upper half of the operands and result, so that any leakage of those bits into zero, sign or overflow shows up. A behavioural model computes carries, nibble borrows and signed ranges with integer arithmetic and checks the flag word after every edge.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int FLAG_W = 16;

    localparam int POS_CF  = 0;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_TF  = 8;
    localparam int POS_IE  = 9;
    localparam int POS_DF  = 10;
    localparam int POS_OF  = 11;

    localparam int CTL_N   = 3;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_HOLD  = 2'd3
    } op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

    function automatic logic [FLAG_W-1:0] pack_flags(input status_t s,
                                                     input logic [CTL_N-1:0] c);
        logic [FLAG_W-1:0] w;
        w          = '0;
        w[POS_CF]  = s.cf;
        w[POS_PF]  = s.pf;
        w[POS_AF]  = s.af;
        w[POS_ZF]  = s.zf;
        w[POS_SF]  = s.sf;
        w[POS_OF]  = s.of;
        w[POS_TF]  = c[0];
        w[POS_IE]  = c[1];
        w[POS_DF]  = c[2];
        return w;
    endfunction

endpackage

// File: rtl/flagu_status_calc.sv
module flagu_status_calc
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              carry_in,
    output status_t           nxt
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int NIB    = BYTE_W / 2;

    logic a_s, b_s, r_s, zero_w, zero_b, ovf_add, ovf_sub, nib_c;

    always_comb begin
        a_s     = word_mode ? a[DATA_W-1]   : a[BYTE_W-1];
        b_s     = word_mode ? b[DATA_W-1]   : b[BYTE_W-1];
        r_s     = word_mode ? res[DATA_W-1] : res[BYTE_W-1];
        zero_w  = (res == '0);
        zero_b  = (res[BYTE_W-1:0] == '0);
        ovf_add = (a_s == b_s) && (r_s != a_s);
        ovf_sub = (a_s != b_s) && (r_s != a_s);
        nib_c   = a[NIB] ^ b[NIB] ^ res[NIB];

        nxt.pf  = ~^res[BYTE_W-1:0];
        nxt.zf  = word_mode ? zero_w : zero_b;
        nxt.sf  = r_s;
        case (op)
            OP_ADD: begin
                nxt.cf = carry_in;
                nxt.af = nib_c;
                nxt.of = ovf_add;
            end
            OP_SUB: begin
                nxt.cf = carry_in;
                nxt.af = nib_c;
                nxt.of = ovf_sub;
            end
            default: begin
                nxt.cf = 1'b0;
                nxt.af = 1'b0;
                nxt.of = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flagu_store.sv
module flagu_store
    import flagu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             stat_we,
    input  logic             carry_in,
    input  status_t          stat_nxt,
    input  logic [CTL_N-1:0] ctl_we,
    input  logic [CTL_N-1:0] ctl_wdata,
    output status_t          stat_q,
    output logic [CTL_N-1:0] ctl_q
);
    logic load;
    assign load = stat_we && (op != OP_HOLD);

    always_ff @(posedge clk) begin
        if (rst)       stat_q <= '0;
        else if (load) stat_q <= stat_nxt;
    end

    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst)            ctl_q[i] <= 1'b0;
            else if (ctl_we[i]) ctl_q[i] <= ctl_wdata[i];
        end

        assert_ctl_keep_R8: assert property (@(posedge clk) disable iff (rst)
            !ctl_we[i] |=> $stable(ctl_q[i]));
        assert_ctl_load_R8: assert property (@(posedge clk) disable iff (rst)
            ctl_we[i] |=> ctl_q[i] == $past(ctl_wdata[i]));
    end

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!stat_we || op == OP_HOLD) |=> $stable(stat_q));
    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_we && op == OP_LOGIC) |=> (!stat_q.cf && !stat_q.of && !stat_q.af));
    assert_carry_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (stat_we && (op == OP_ADD || op == OP_SUB)) |=> stat_q.cf == $past(carry_in));
    assert_zero_not_neg_R5: assert property (@(posedge clk) disable iff (rst)
        stat_q.zf |-> !stat_q.sf);

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            op_class,
    input  logic                  word_mode,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [DATA_W-1:0]     alu_result,
    input  logic                  alu_carry,
    input  logic                  stat_we,
    input  logic [2:0]            ctl_we,
    input  logic [2:0]            ctl_wdata,
    output logic [15:0]           flags_q
);
    op_e              op;
    status_t          stat_nxt;
    status_t          stat_q;
    logic [CTL_N-1:0] ctl_q;

    assign op = op_e'(op_class);

    flagu_status_calc #(.DATA_W(DATA_W)) u_calc (
        .op        (op),
        .word_mode (word_mode),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (alu_result),
        .carry_in  (alu_carry),
        .nxt       (stat_nxt)
    );

    flagu_store u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .stat_we   (stat_we),
        .carry_in  (alu_carry),
        .stat_nxt  (stat_nxt),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .stat_q    (stat_q),
        .ctl_q     (ctl_q)
    );

    assign flags_q = pack_flags(stat_q, ctl_q);

    assert_dead_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (flags_q & 16'hF02A) == 16'h0000);

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_class = '0;
    logic        word_mode = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, alu_result = '0;
    logic        alu_carry = 1'b0, stat_we = 1'b0;
    logic [2:0]  ctl_we = '0, ctl_wdata = '0;
    logic [15:0] flags_q;

    int n_vec = 0;
    int n_bad = 0;
    int exp_flags = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_unit dut (
        .clk(clk), .rst(rst), .op_class(op_class), .word_mode(word_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_result(alu_result),
        .alu_carry(alu_carry), .stat_we(stat_we), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .flags_q(flags_q)
    );

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w-1))) ? v - (1 << w) : v;
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (int'(flags_q) != exp_flags) begin
            n_bad++;
            $display("FAIL %s: flags actual %04h expected %04h", tag, flags_q, exp_flags);
        end
    endtask

    // op: 0 add, 1 sub, 2 logic (xor), 3 hold; hi_junk goes into upper result byte in byte mode
    task automatic apply(input int op, input int wm, input int a, input int b,
                         input int swe, input int cwe, input int cwd, input string tag);
        int w, mask, am, bm, r, c, af, sv, of, ones, st;
        w    = wm ? 16 : 8;
        mask = (1 << w) - 1;
        am   = a & mask;
        bm   = b & mask;
        af = 0; of = 0; c = 0; sv = 0;
        case (op)
            0: begin
                r  = am + bm;
                c  = (r >> w) & 1;
                r  = r & mask;
                af = (((am & 15) + (bm & 15)) > 15) ? 1 : 0;
                sv = sx(am, w) + sx(bm, w);
            end
            1: begin
                r  = (am - bm) & mask;
                c  = (am < bm) ? 1 : 0;
                af = ((am & 15) < (bm & 15)) ? 1 : 0;
                sv = sx(am, w) - sx(bm, w);
            end
            default: r = (am ^ bm) & mask;
        endcase
        if (op < 2) of = (sv > (1 << (w-1)) - 1 || sv < -(1 << (w-1))) ? 1 : 0;
        opnd_a     = 16'(a);
        opnd_b     = 16'(b);
        alu_result = wm ? 16'(r) : 16'(r | 32'h5A00);
        alu_carry  = (op >= 2) ? 1'b1 : c[0];
        op_class   = 2'(op);
        word_mode  = wm[0];
        stat_we    = swe[0];
        ctl_we     = 3'(cwe);
        ctl_wdata  = 3'(cwd);
        if (swe != 0 && op != 3) begin
            ones = 0;
            for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
            st = 0;
            if (op < 2) st |= c;
            if ((ones % 2) == 0) st |= 1 << 2;
            if (op < 2) st |= af << 4;
            if (r == 0) st |= 1 << 6;
            st |= ((r >> (w-1)) & 1) << 7;
            if (op < 2) st |= of << 11;
            exp_flags = (exp_flags & 32'h0700) | st;
        end
        for (int i = 0; i < 3; i++)
            if ((cwe >> i) & 1)
                exp_flags = (exp_flags & ~(1 << (8+i))) | (((cwd >> i) & 1) << (8+i));
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_flags = 0;
        check("R1 reset");
        apply(0, 1, 16'h7FFF, 16'h0001, 1, 0, 0, "R7 word add overflow");
        apply(0, 1, 16'hFFFF, 16'h0001, 1, 0, 0, "R2 R5 word add carry zero");
        apply(0, 0, 16'h337F, 16'hC001, 1, 0, 0, "R6 R7 byte add junk upper");
        apply(0, 0, 16'h12FF, 16'h3401, 1, 0, 0, "R5 byte zero upper ignored");
        apply(1, 0, 16'h0010, 16'h0001, 1, 0, 0, "R4 byte nibble borrow");
        apply(0, 1, 16'h0008, 16'h0008, 1, 0, 0, "R4 nibble carry add");
        apply(1, 1, 16'h0000, 16'h0001, 1, 0, 0, "R2 word borrow");
        apply(1, 1, 16'h8000, 16'h0001, 1, 0, 0, "R7 word sub overflow");
        apply(2, 1, 16'h0F00, 16'h0E00, 1, 0, 0, "R9 logic clears cf of af");
        apply(2, 1, 16'h0000, 16'h0001, 1, 0, 0, "R3 odd low byte parity");
        apply(2, 1, 16'hFF03, 16'h0000, 1, 0, 0, "R3 parity low byte only");
        apply(0, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R10 stat_we low holds");
        apply(3, 1, 16'h0000, 16'h0000, 1, 0, 0, "R10 hold opcode");
        apply(3, 1, 16'h0000, 16'h0000, 0, 4, 4, "R8 set direction only");
        apply(0, 1, 16'h1234, 16'h4321, 1, 3, 3, "R8 set tf ie with status");
        apply(1, 0, 16'h0005, 16'h0009, 1, 2, 0, "R8 clear ie only");
        apply(2, 0, 16'h0000, 16'h0000, 1, 0, 7, "R8 data without enable");
        for (int n = 0; n < 400; n++)
            apply(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 3)) != 0 ? 1 : 0, int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 7)), "R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
        rst = 1'b1;
        exp_flags = 0;
        @(posedge clk);
        @(negedge clk);
        check("R1 re-reset");
        rst = 1'b0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule